// File: doc/BRIEF.md
# Rate sensor power-up self-check sequencer

This block brings a rate sensor from power-on to a usable state. A start pulse triggers a fixed series of timed frame exchanges, which are carried out through a request/response port to a separate frame engine. The delays between exchanges are counted on an external millisecond tick. The first exchange asks the sensor to run its internal self-check. The next three exchanges are plain sensor-data requests. The last exchange reads the sensor's fault register. The block compares every raw 32-bit reply against the pattern a healthy sensor returns at that step.

The result is reported on three status outputs and a two-bit error code. `ready_o` means every gate passed. `failed_o` together with `err_code_o` identifies which gate stopped the sequence. `warn_o` flags an unexpected first reply, which is not fatal. Because the tick is an input, a bench or a faster system can shorten the delays without changing the logic. Bit serialization and the conversion of rate or temperature values are handled elsewhere.

Top module: `gyro_boot_seq`

## Requirements
- R1: After reset, and until `start_i` is pulsed, `ready_o`, `failed_o` and `warn_o` are low, `err_code_o` is 0 and `req_valid_o` stays low, whatever the tick or response inputs do.
- R2: After start, the first request is raised on the clock edge that samples the INIT_DELAY_MS-th tick, and never earlier. Its command word is 0x20000003: the sensor-data opcode, with the self-check bit (bit 1) and the parity bit (bit 0) set.
- R3: If the first reply differs from 0x00000001, `warn_o` goes high on the edge that accepts that reply. The sequence continues regardless.
- R4: The second and third requests each follow STEP_DELAY_MS ticks after the previous reply and carry 0x20000000. The fourth request carries the same word and is raised on the clock edge right after the third reply, with no tick needed.
- R5: The third reply passes only if its bits 7:0, with bit 0 forced to 1, equal 0xFF and its bits 27:26 equal 2. Otherwise `failed_o` rises with `err_code_o` = 1 and no further request is issued.
- R6: The fourth reply is checked by the same rule. If it fails, `failed_o` rises with `err_code_o` = 2.
- R7: The fault-register read command 0x80140000 (address 0x0A in bits 23:17, parity bit clear) is issued right after a passing fourth reply. The fault word is taken from reply bits 20:5. If any of its low 12 bits (reply bits 16:5) is set, `failed_o` rises with `err_code_o` = 3. Those 12 bits indicate, from bit 0 upward: parity, check, self-test, power, power-on reset, memory, quadrature, PLL, undervoltage, overvoltage, amplitude and general fail. Bits 15:12 of the fault word are ignored.
- R8: `ready_o` rises only when the fault read passes, with `err_code_o` = 0. `ready_o` and `failed_o` are never high together, and `err_code_o` is nonzero exactly while `failed_o` is high.
- R9: A start pulse in any state clears `ready_o`, `failed_o`, `warn_o` and `err_code_o` on the next edge and restarts the full sequence from the first delay.
- R10: Once raised, `req_valid_o` and `req_cmd_o` hold until `req_ready_i` is seen. A `rsp_valid_i` pulse while no reply is awaited has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts or restarts the sequence |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| req_valid_o | output | 1 | Frame request to the frame engine |
| req_ready_i | input | 1 | Frame engine accepts the request |
| req_cmd_o | output | 32 | Command word to send |
| rsp_valid_i | input | 1 | Reply word is valid |
| rsp_data_i | input | 32 | Raw 32-bit reply |
| ready_o | output | 1 | All checks passed |
| warn_o | output | 1 | First reply was unexpected |
| failed_o | output | 1 | Sequence stopped on a check |
| err_code_o | output | 2 | 0 none, 1 third reply, 2 fourth reply, 3 fault bit |

## Verification
After a start pulse, the status outputs are clear at the next falling edge. During each delay, `req_valid_o` must stay low after every tick except the last one. After the last tick it is already high at the following falling edge, so the bench drives exactly one tick per two half-cycles and samples once after each tick. A reply accepted on a rising edge updates `warn_o`, `failed_o`, `err_code_o` and `ready_o` by the next falling edge, or raises the next immediate request by then, and the bench samples there. Every reply variant is swept with a short delay configuration, and the expected verdict is computed from the masked-pattern rule.

// File: rtl/gyro_boot_pkg.sv
package gyro_boot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ISSUE,
        ST_AWAIT,
        ST_READY,
        ST_FAIL
    } seq_state_e;

    typedef enum logic [2:0] {
        STEP_SELFCHK,
        STEP_SETTLE,
        STEP_THIRD,
        STEP_FOURTH,
        STEP_FAULT
    } seq_step_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_THIRD  = 2'd1,
        ERR_FOURTH = 2'd2,
        ERR_FAULT  = 2'd3
    } err_code_e;

    typedef struct packed {
        seq_state_e st;
        seq_step_e  step;
        logic       warn;
        err_code_e  err;
    } seq_regs_t;

    localparam logic [31:0] CMD_SENSOR   = 32'h2000_0000;
    localparam logic [31:0] CMD_SELFCHK  = 32'h2000_0003;
    localparam logic [31:0] CMD_FAULT_RD = 32'h8014_0000;
    localparam logic [31:0] POR_REPLY    = 32'h0000_0001;

    localparam int          STAT_LSB     = 26;
    localparam logic [1:0]  STAT_GOOD    = 2'd2;
    localparam int          FAULT_LSB    = 5;
    localparam int          FAULT_BITS   = 12;

endpackage

// File: rtl/gyro_boot_timer.sv
module gyro_boot_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             last_tick;

    always_comb begin
        last_tick = (cnt_q + 1'b1) == limit_i;
        expired_o = run_i && tick_i && last_tick;
        cnt_d     = cnt_q;
        if (clear_i || expired_o) begin
            cnt_d = '0;
        end else if (run_i && tick_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: the count never reaches the active limit
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit_i);

endmodule

// File: rtl/gyro_boot_eval.sv
module gyro_boot_eval
    import gyro_boot_pkg::*;
(
    input  logic [31:0]           reply_i,
    output logic                  por_ok_o,
    output logic                  frame_ok_o,
    output logic [FAULT_BITS-1:0] fault_bits_o,
    output logic                  fault_clear_o
);

    logic [7:0] low_byte;
    logic [1:0] status;

    always_comb begin
        por_ok_o      = reply_i == POR_REPLY;
        low_byte      = reply_i[7:0] | 8'h01;
        status        = reply_i[STAT_LSB +: 2];
        frame_ok_o    = (low_byte == 8'hFF) && (status == STAT_GOOD);
        fault_bits_o  = reply_i[FAULT_LSB +: FAULT_BITS];
        fault_clear_o = fault_bits_o == '0;
    end

endmodule

// File: rtl/gyro_boot_seq.sv
module gyro_boot_seq
    import gyro_boot_pkg::*;
#(
    parameter int INIT_DELAY_MS = 100,
    parameter int STEP_DELAY_MS = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        ms_tick_i,
    output logic        req_valid_o,
    input  logic        req_ready_i,
    output logic [31:0] req_cmd_o,
    input  logic        rsp_valid_i,
    input  logic [31:0] rsp_data_i,
    output logic        ready_o,
    output logic        warn_o,
    output logic        failed_o,
    output logic [1:0]  err_code_o
);

    localparam int MAX_DELAY = (INIT_DELAY_MS > STEP_DELAY_MS) ? INIT_DELAY_MS : STEP_DELAY_MS;
    localparam int CNT_W     = $clog2(MAX_DELAY + 1);
    localparam logic [CNT_W-1:0] INIT_LIM = CNT_W'(INIT_DELAY_MS);
    localparam logic [CNT_W-1:0] STEP_LIM = CNT_W'(STEP_DELAY_MS);

    seq_regs_t             r_d, r_q;
    logic                  tmr_clear, tmr_run, tmr_expired;
    logic [CNT_W-1:0]      tmr_limit;
    logic                  por_ok, frame_ok, fault_clear;
    logic [FAULT_BITS-1:0] fault_bits;

    gyro_boot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (tmr_clear),
        .run_i     (tmr_run),
        .tick_i    (ms_tick_i),
        .limit_i   (tmr_limit),
        .expired_o (tmr_expired)
    );

    gyro_boot_eval u_eval (
        .reply_i       (rsp_data_i),
        .por_ok_o      (por_ok),
        .frame_ok_o    (frame_ok),
        .fault_bits_o  (fault_bits),
        .fault_clear_o (fault_clear)
    );

    always_comb begin
        r_d       = r_q;
        tmr_run   = r_q.st == ST_WAIT;
        tmr_clear = start_i || (r_q.st != ST_WAIT);
        tmr_limit = (r_q.step == STEP_SELFCHK) ? INIT_LIM : STEP_LIM;

        unique case (r_q.step)
            STEP_SELFCHK: req_cmd_o = CMD_SELFCHK;
            STEP_FAULT:   req_cmd_o = CMD_FAULT_RD;
            default:      req_cmd_o = CMD_SENSOR;
        endcase

        case (r_q.st)
            ST_WAIT: begin
                if (tmr_expired) r_d.st = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (req_ready_i) r_d.st = ST_AWAIT;
            end
            ST_AWAIT: begin
                if (rsp_valid_i) begin
                    case (r_q.step)
                        STEP_SELFCHK: begin
                            if (!por_ok) r_d.warn = 1'b1;
                            r_d.step = STEP_SETTLE;
                            r_d.st   = ST_WAIT;
                        end
                        STEP_SETTLE: begin
                            r_d.step = STEP_THIRD;
                            r_d.st   = ST_WAIT;
                        end
                        STEP_THIRD: begin
                            if (!frame_ok) begin
                                r_d.st  = ST_FAIL;
                                r_d.err = ERR_THIRD;
                            end else begin
                                r_d.step = STEP_FOURTH;
                                r_d.st   = ST_ISSUE;
                            end
                        end
                        STEP_FOURTH: begin
                            if (!frame_ok) begin
                                r_d.st  = ST_FAIL;
                                r_d.err = ERR_FOURTH;
                            end else begin
                                r_d.step = STEP_FAULT;
                                r_d.st   = ST_ISSUE;
                            end
                        end
                        STEP_FAULT: begin
                            if (!fault_clear) begin
                                r_d.st  = ST_FAIL;
                                r_d.err = ERR_FAULT;
                            end else begin
                                r_d.st = ST_READY;
                            end
                        end
                        default: r_d.st = ST_IDLE;
                    endcase
                end
            end
            default: ;
        endcase

        if (start_i) begin
            r_d.st   = ST_WAIT;
            r_d.step = STEP_SELFCHK;
            r_d.warn = 1'b0;
            r_d.err  = ERR_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, step: STEP_SELFCHK, warn: 1'b0, err: ERR_NONE};
        else        r_q <= r_d;
    end

    assign req_valid_o = r_q.st == ST_ISSUE;
    assign ready_o     = r_q.st == ST_READY;
    assign failed_o    = r_q.st == ST_FAIL;
    assign warn_o      = r_q.warn;
    assign err_code_o  = r_q.err;

    // R8: success and failure are exclusive
    p_ready_fail_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_o && failed_o));

    // R8: a code is present exactly while failed
    p_code_with_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        failed_o == (err_code_o != 2'd0));

    // R8: ready only follows an accepted reply
    p_ready_after_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(rsp_valid_i));

    // R9: start wipes every status output
    p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!ready_o && !failed_o && !warn_o && err_code_o == 2'd0));

    // R10: a pending request holds its word
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i && !start_i) |=> (req_valid_o && $stable(req_cmd_o)));

    // R7: a fault code needs a fault bit in the reply just taken
    p_fault_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (failed_o && err_code_o == 2'd3 && !$past(failed_o)) |-> $past(|rsp_data_i[16:5]));

endmodule

// File: tb/gyro_boot_seq_bench.sv
`timescale 1ns/1ps
module gyro_boot_seq_bench;

    localparam int INIT = 5;
    localparam int STEP = 3;
    localparam logic [31:0] GOOD = 32'h0800_00FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        ms_tick_i = 1'b0;
    logic        req_ready_i = 1'b0;
    logic        rsp_valid_i = 1'b0;
    logic [31:0] rsp_data_i = '0;
    logic        req_valid_o, ready_o, warn_o, failed_o;
    logic [31:0] req_cmd_o;
    logic [1:0]  err_code_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gyro_boot_seq #(.INIT_DELAY_MS(INIT), .STEP_DELAY_MS(STEP)) u_gyro_boot_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ms_tick_i(ms_tick_i),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_cmd_o(req_cmd_o),
        .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
        .ready_o(ready_o), .warn_o(warn_o), .failed_o(failed_o), .err_code_o(err_code_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit frame_good(input logic [31:0] r);
        return (((r[7:0] | 8'h01) == 8'hFF) && (r[27:26] == 2'd2));
    endfunction

    task automatic check_status(input string tag, input bit rdy, input bit fl, input bit wn, input int code);
        chk(ready_o == rdy, {tag, " ready"}, 32'(ready_o), 32'(rdy));
        chk(failed_o == fl, {tag, " failed"}, 32'(failed_o), 32'(fl));
        chk(warn_o == wn, {tag, " warn"}, 32'(warn_o), 32'(wn));
        chk(err_code_o == 2'(code), {tag, " code"}, 32'(err_code_o), 32'(code));
    endtask

    task automatic tick_wait(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            ms_tick_i = 1'b1;
            @(negedge clk);
            ms_tick_i = 1'b0;
            chk(req_valid_o == (i == n - 1), {tag, " request timing"}, 32'(req_valid_o), 32'(i == n - 1));
        end
    endtask

    task automatic serve(input logic [31:0] exp_cmd, input logic [31:0] reply, input string tag);
        chk(req_valid_o == 1'b1, {tag, " request raised"}, 32'(req_valid_o), 32'd1);
        chk(req_cmd_o == exp_cmd, {tag, " command"}, req_cmd_o, exp_cmd);
        @(negedge clk);
        chk(req_valid_o && req_cmd_o == exp_cmd, "R10 request held", req_cmd_o, exp_cmd);
        req_ready_i = 1'b1;
        @(negedge clk);
        req_ready_i = 1'b0;
        chk(req_valid_o == 1'b0, {tag, " request dropped"}, 32'(req_valid_o), 32'd0);
        rsp_valid_i = 1'b1;
        rsp_data_i  = reply;
        @(negedge clk);
        rsp_valid_i = 1'b0;
    endtask

    task automatic do_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check_status("R9 after start", 1'b0, 1'b0, 1'b0, 0);
        chk(req_valid_o == 1'b0, "R9 no request after start", 32'(req_valid_o), 32'd0);
    endtask

    task automatic run_seq(input logic [31:0] r1, input logic [31:0] r3, input logic [31:0] r4,
                           input logic [11:0] flt);
        bit wn;
        wn = (r1 != 32'h1);
        do_start();
        tick_wait(INIT, "R2");
        serve(32'h2000_0003, r1, "R2");
        chk(warn_o == wn, "R3 warn after first reply", 32'(warn_o), 32'(wn));
        tick_wait(STEP, "R4 second");
        serve(32'h2000_0000, 32'h1234_5678, "R4 second");
        tick_wait(STEP, "R4 third");
        serve(32'h2000_0000, r3, "R4 third");
        if (!frame_good(r3)) begin
            check_status("R5 third reply", 1'b0, 1'b1, wn, 1);
            chk(req_valid_o == 1'b0, "R5 no request after fail", 32'(req_valid_o), 32'd0);
            return;
        end
        serve(32'h2000_0000, r4, "R4 fourth immediate");
        if (!frame_good(r4)) begin
            check_status("R6 fourth reply", 1'b0, 1'b1, wn, 2);
            return;
        end
        serve(32'h8014_0000, {11'h0, 4'hA, flt, 5'h1F}, "R7 fault read");
        if (flt != 12'h0) check_status("R7 fault gate", 1'b0, 1'b1, wn, 3);
        else              check_status("R8 ready", 1'b1, 1'b0, wn, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_status("R1 reset", 1'b0, 1'b0, 1'b0, 0);

        // R1: ticks and stray replies do nothing before start
        for (int i = 0; i < 2 * INIT; i++) begin
            ms_tick_i = 1'b1;
            rsp_valid_i = (i % 3 == 0);
            rsp_data_i = 32'hDEAD_0000;
            @(negedge clk);
            ms_tick_i = 1'b0;
            rsp_valid_i = 1'b0;
            chk(req_valid_o == 1'b0, "R1 idle no request", 32'(req_valid_o), 32'd0);
        end
        check_status("R1 idle", 1'b0, 1'b0, 1'b0, 0);

        // R2 R3 R8: clean pass, then first-reply variants
        run_seq(32'h1, GOOD, GOOD, 12'h0);
        run_seq(32'h0, GOOD, GOOD, 12'h0);
        run_seq(32'h3, GOOD, GOOD, 12'h0);
        run_seq(32'h8000_0001, GOOD, GOOD, 12'h0);

        // R5: third reply sweep over status field and low byte
        for (int s = 0; s < 4; s++) begin
            for (int b = 0; b < 4; b++) begin
                logic [7:0] lb;
                lb = (b == 0) ? 8'hFF : (b == 1) ? 8'hFE : (b == 2) ? 8'h7F : 8'hEF;
                run_seq(32'h1, {4'h0, 2'(s), 18'h0, lb}, GOOD, 12'h0);
            end
        end

        // R6: fourth reply sweep
        for (int s = 0; s < 4; s++) begin
            run_seq(32'h0, GOOD, {4'hF, 2'(s), 18'h3FFFF, 8'hFE}, 12'h0);
            run_seq(32'h1, GOOD, {4'h0, 2'(s), 18'h0, 8'hFD}, 12'h0);
        end

        // R7: each fault bit alone
        for (int k = 0; k < 12; k++) begin
            run_seq(32'h1, GOOD, GOOD, 12'(1 << k));
        end

        // R10 R9: stray reply while waiting, then restart mid-wait
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        ms_tick_i = 1'b1;
        @(negedge clk);
        ms_tick_i = 1'b0;
        rsp_valid_i = 1'b1;
        rsp_data_i = 32'h0;
        @(negedge clk);
        rsp_valid_i = 1'b0;
        check_status("R10 stray reply ignored", 1'b0, 1'b0, 1'b0, 0);
        chk(req_valid_o == 1'b0, "R10 stray reply no request", 32'(req_valid_o), 32'd0);
        tick_wait(INIT - 1, "R10 timing kept");
        serve(32'h2000_0003, 32'h5, "R10 first");
        chk(warn_o == 1'b1, "R3 warn set before restart", 32'(warn_o), 32'd1);
        run_seq(32'h1, GOOD, GOOD, 12'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule